// File: doc/BRIEF.md
# Packet Encapsulator with 32-to-128-bit Width Upsizer

The block takes records from a 32-bit stream and turns each one into a packet of 128-bit words. The first word of a record carries the start flag and gives the payload length in bytes. The payload words follow it, and the last of them carries the end flag. When the block accepts the length word, it builds one header word from that length and from two configuration registers that software writes: a destination identifier and a destination buffer tag. It packs the payload four input words to a beat. When the record ends, it writes one footer word holding a running packet sequence number and a truncation error flag.

Header and footer words go into a control FIFO. Payload beats go into a separate payload FIFO. A downstream engine drains both FIFOs through show-ahead read ports. Any payload beyond `MAX_BYTES` (4 KB by default) is cut off, and the footer flags the cut. A final beat that is only partly filled is padded with zero lanes.

The controller has five states:

- `ST_IDLE` waits for a length word and discards anything else.
- `ST_PAYLOAD` packs the words it keeps.
- `ST_DROP` discards the words past the limit until the end flag.
- `ST_FLUSH` writes out a partly filled beat.
- `ST_FOOTER` writes the footer.

The transitions are:

- `ST_IDLE` goes to `ST_PAYLOAD` when a length word is accepted with a non-zero kept count and no end flag.
- `ST_IDLE` goes to `ST_DROP` on a length word with a kept count of 0 and no end flag.
- `ST_IDLE` goes to `ST_FOOTER` on a length word with the end flag.
- `ST_PAYLOAD` goes to `ST_FOOTER` on the end flag when the beat just completed.
- `ST_PAYLOAD` goes to `ST_FLUSH` on the end flag when lanes are still pending.
- `ST_PAYLOAD` goes to `ST_DROP` when the kept count runs out before the end flag.
- `ST_DROP` goes to `ST_FLUSH` or `ST_FOOTER` on the end flag, depending on whether lanes are pending.
- `ST_FLUSH` goes to `ST_FOOTER` once the padded beat is written.
- `ST_FOOTER` goes to `ST_IDLE` once the footer is written.

Top module: `pkt_encap`

## Requirements
- R1: After reset, `in_ready` is 1, both FIFOs are empty, and the first packet uses sequence number 0.
- R2: Accepting a word with `in_sop` set while idle writes one header word to the control FIFO. The header holds kind 2'b01 in bits [127:126], the byte length in [15:0], the destination identifier in [23:16] and the buffer tag in [95:64]. All other bits are zero.
- R3: Payload words are packed four to a 128-bit beat, with the first word of the beat in bits [31:0] and the fourth in bits [127:96].
- R4: If a record's kept word count is not a multiple of four, its last beat carries zeros in the unused upper lanes. The header length keeps the true byte count.
- R5: After the last beat of a record, the block writes one footer word. The footer holds kind 2'b10 in [127:126], the sequence number in [15:0] (0, 1, 2, … per packet), the error flag in bit [32], and zeros elsewhere.
- R6: For a length above `MAX_BYTES`, the header length is `MAX_BYTES`. Only the first `MAX_BYTES/4` payload words are kept, later words up to `in_eop` are consumed and discarded, and the footer error flag is 1. Otherwise the flag is 0.
- R7: The control FIFO strictly alternates header and footer words. Every payload beat of a record is written after its header and before its footer.
- R8: Words presented while idle without `in_sop` are accepted and discarded. They produce no output.
- R9: `in_ready` is low whenever the FIFO that the next accepted word would write into is full. Under any stall pattern on the read side no word is lost.
- R10: A configuration write to address 0 sets the destination identifier from `cfg_wdata[7:0]`, and address 1 sets the buffer tag. Writes to other addresses change nothing.
- R11: A length word that also carries `in_eop` gives a header with length 0 followed directly by a footer, with no payload beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept the input word |
| in_sop | input | 1 | Word is the length word of a record |
| in_eop | input | 1 | Word is the last word of a record |
| in_data | input | 32 | Input word |
| hf_pop | input | 1 | Read strobe of the control FIFO |
| hf_data | output | 128 | Head of the control FIFO (header/footer) |
| hf_empty | output | 1 | Control FIFO empty |
| pl_pop | input | 1 | Read strobe of the payload FIFO |
| pl_data | output | 128 | Head of the payload FIFO |
| pl_empty | output | 1 | Payload FIFO empty |

## Verification
The assertions assume that every record starts with a length word and ends with a word carrying `in_eop`. They also assume that the sender sends exactly `ceil(length/4)` payload words, so the kept-beat bound and the header/footer alternation hold only for well-formed framing. The stimulus builds every record from its length, so it never sends a short or overlong record. The only unframed words it sends are deliberate stray words placed while the block is idle. The read side stalls at random, and one phase stops it altogether so that both FIFOs fill, but nothing ever pops an empty FIFO.

// File: rtl/pkt_enc_pkg.sv
package pkt_enc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAYLOAD,
        ST_DROP,
        ST_FLUSH,
        ST_FOOTER
    } enc_state_t;

    localparam logic [1:0] KIND_HDR = 2'b01;
    localparam logic [1:0] KIND_FTR = 2'b10;

endpackage

// File: rtl/pkt_enc_fifo.sv
module pkt_enc_fifo #(
    parameter int W     = 128,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_q] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) begin
                rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
            end
            cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

endmodule

// File: rtl/pkt_enc_cfg.sv
module pkt_enc_cfg #(
    parameter int DEST_W = 8,
    parameter int TAG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [31:0]       wdata,
    output logic [DEST_W-1:0] dest_id,
    output logic [TAG_W-1:0]  buf_tag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_id <= '0;
            buf_tag <= '0;
        end else if (we) begin
            unique case (addr)
                2'd0:    dest_id <= wdata[DEST_W-1:0];
                2'd1:    buf_tag <= wdata[TAG_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pkt_enc_packer.sv
module pkt_enc_packer #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IN_W-1:0]  word,
    input  logic             clear,
    output logic             beat_done,
    output logic             pending,
    output logic [OUT_W-1:0] full_beat,
    output logic [OUT_W-1:0] pad_beat
);
    localparam int LANES = OUT_W / IN_W;
    localparam int IDX_W = $clog2(LANES);

    logic [IN_W-1:0]  lane_q [LANES-1];
    logic [IDX_W-1:0] idx_q;

    assign beat_done = load && (idx_q == IDX_W'(LANES-1));
    assign pending   = (idx_q != '0);

    for (genvar g = 0; g < LANES-1; g++) begin : g_lane
        assign full_beat[g*IN_W +: IN_W] = lane_q[g];
        assign pad_beat[g*IN_W +: IN_W]  = lane_q[g];

        always_ff @(posedge clk) begin
            if (!rst_n || clear || beat_done) begin
                lane_q[g] <= '0;
            end else if (load && idx_q == IDX_W'(g)) begin
                lane_q[g] <= word;
            end
        end
    end
    assign full_beat[OUT_W-1 -: IN_W] = word;
    assign pad_beat[OUT_W-1 -: IN_W]  = '0;

    always_ff @(posedge clk) begin
        if (!rst_n || clear || beat_done) begin
            idx_q <= '0;
        end else if (load) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // R4
    pad_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !pending);

endmodule

// File: rtl/pkt_encap.sv
module pkt_encap
    import pkt_enc_pkg::*;
#(
    parameter int MAX_BYTES = 4096,
    parameter int HF_DEPTH  = 8,
    parameter int PL_DEPTH  = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_addr,
    input  logic [31:0]  cfg_wdata,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic         in_sop,
    input  logic         in_eop,
    input  logic [31:0]  in_data,
    input  logic         hf_pop,
    output logic [127:0] hf_data,
    output logic         hf_empty,
    input  logic         pl_pop,
    output logic [127:0] pl_data,
    output logic         pl_empty
);
    localparam int IN_W      = 32;
    localparam int OUT_W     = 128;
    localparam int DEST_W    = 8;
    localparam int TAG_W     = 32;
    localparam int SEQ_W     = 16;
    localparam int MAX_WORDS = MAX_BYTES / (IN_W/8);
    localparam int MAX_BEATS = MAX_BYTES / (OUT_W/8);
    localparam int WC_W      = $clog2(MAX_WORDS + 1);
    localparam int BC_W      = $clog2(MAX_BEATS + 1);

    enc_state_t state_q, state_d;

    logic [DEST_W-1:0] dest_id;
    logic [TAG_W-1:0]  buf_tag;
    logic              hf_full, pl_full;
    logic              hf_push, pl_push;
    logic [OUT_W-1:0]  hf_din, pl_din;
    logic              pk_load, pk_clear, pk_done, pk_pending;
    logic [OUT_W-1:0]  pk_full, pk_pad;

    logic [WC_W-1:0]   kept_q, cnt_q;
    logic              trunc_q;
    logic [SEQ_W-1:0]  seq_q;

    logic              acc;
    logic [32:0]       size_words;
    logic [WC_W-1:0]   size_kept;
    logic              size_trunc;
    logic [15:0]       size_len;
    logic [OUT_W-1:0]  hdr_word, ftr_word;

    pkt_enc_cfg #(.DEST_W(DEST_W), .TAG_W(TAG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .dest_id(dest_id), .buf_tag(buf_tag)
    );

    pkt_enc_packer #(.IN_W(IN_W), .OUT_W(OUT_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .load(pk_load), .word(in_data),
        .clear(pk_clear), .beat_done(pk_done), .pending(pk_pending),
        .full_beat(pk_full), .pad_beat(pk_pad)
    );

    pkt_enc_fifo #(.W(OUT_W), .DEPTH(HF_DEPTH)) u_hf_fifo (
        .clk(clk), .rst_n(rst_n), .push(hf_push), .din(hf_din),
        .pop(hf_pop), .dout(hf_data), .full(hf_full), .empty(hf_empty)
    );

    pkt_enc_fifo #(.W(OUT_W), .DEPTH(PL_DEPTH)) u_pl_fifo (
        .clk(clk), .rst_n(rst_n), .push(pl_push), .din(pl_din),
        .pop(pl_pop), .dout(pl_data), .full(pl_full), .empty(pl_empty)
    );

    // length word decode
    always_comb begin
        size_words = ({1'b0, in_data} + 33'd3) >> 2;
        size_trunc = (in_data > 32'(MAX_BYTES));
        size_kept  = (size_words > 33'(MAX_WORDS)) ? WC_W'(MAX_WORDS)
                                                    : size_words[WC_W-1:0];
        size_len   = size_trunc ? 16'(MAX_BYTES) : in_data[15:0];
    end

    always_comb begin
        hdr_word                    = '0;
        hdr_word[OUT_W-1 -: 2]      = KIND_HDR;
        hdr_word[15:0]              = size_len;
        hdr_word[16 +: DEST_W]      = dest_id;
        hdr_word[64 +: TAG_W]       = buf_tag;
        ftr_word                    = '0;
        ftr_word[OUT_W-1 -: 2]      = KIND_FTR;
        ftr_word[SEQ_W-1:0]         = seq_q;
        ftr_word[32]                = trunc_q;
    end

    assign acc = in_valid && in_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc && in_sop) begin
                    if (in_eop)               state_d = ST_FOOTER;
                    else if (size_kept == '0) state_d = ST_DROP;
                    else                      state_d = ST_PAYLOAD;
                end
            end
            ST_PAYLOAD: begin
                if (acc) begin
                    if (in_eop)                    state_d = pk_done ? ST_FOOTER : ST_FLUSH;
                    else if (cnt_q + 1'b1 == kept_q) state_d = ST_DROP;
                end
            end
            ST_DROP: begin
                if (acc && in_eop) state_d = pk_pending ? ST_FLUSH : ST_FOOTER;
            end
            ST_FLUSH: begin
                if (!pl_full) state_d = ST_FOOTER;
            end
            ST_FOOTER: begin
                if (!hf_full) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = 1'b0;
        hf_push  = 1'b0;
        hf_din   = hdr_word;
        pl_push  = 1'b0;
        pl_din   = pk_full;
        pk_load  = 1'b0;
        pk_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = !hf_full;
                hf_push  = in_valid && !hf_full && in_sop;
            end
            ST_PAYLOAD: begin
                in_ready = !pl_full;
                pk_load  = in_valid && !pl_full;
                pl_push  = pk_done;
            end
            ST_DROP: begin
                in_ready = 1'b1;
            end
            ST_FLUSH: begin
                pl_din   = pk_pad;
                pl_push  = !pl_full;
                pk_clear = !pl_full;
            end
            ST_FOOTER: begin
                hf_din  = ftr_word;
                hf_push = !hf_full;
            end
            default: ;
        endcase
    end

    // per-record registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kept_q  <= '0;
            cnt_q   <= '0;
            trunc_q <= 1'b0;
            seq_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && acc && in_sop) begin
                kept_q  <= size_kept;
                cnt_q   <= '0;
                trunc_q <= size_trunc;
            end
            if (state_q == ST_PAYLOAD && acc) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == ST_FOOTER && hf_push) begin
                seq_q <= seq_q + 1'b1;
            end
        end
    end

    // checker state: header/footer pairing and beat count
    logic            hdr_open_q;
    logic [BC_W-1:0] beats_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_open_q <= 1'b0;
            beats_q    <= '0;
        end else begin
            if (hf_push && !hf_full) hdr_open_q <= !hdr_open_q;
            if (hf_push && !hdr_open_q) beats_q <= '0;
            else if (pl_push && !pl_full) beats_q <= beats_q + 1'b1;
        end
    end

    // R7
    hdr_then_ftr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hf_push && hdr_open_q) |-> hf_din[OUT_W-1 -: 2] == KIND_FTR);

    // R7
    ftr_then_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hf_push && !hdr_open_q) |-> hf_din[OUT_W-1 -: 2] == KIND_HDR);

    // R7
    payload_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_push |-> hdr_open_q);

    // R6
    beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_push |-> beats_q < BC_W'(MAX_BEATS));

    // R5
    footer_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FOOTER && !hf_full) |=> state_q == ST_IDLE);

endmodule

// File: tb/test_pkt_encap.sv
module test_pkt_encap;
    localparam int MAXB = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_addr = '0;
    logic [31:0]  cfg_wdata = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_sop = 1'b0;
    logic         in_eop = 1'b0;
    logic [31:0]  in_data = '0;
    logic         hf_pop = 1'b0;
    logic [127:0] hf_data;
    logic         hf_empty;
    logic         pl_pop = 1'b0;
    logic [127:0] pl_data;
    logic         pl_empty;

    pkt_encap #(.MAX_BYTES(MAXB), .HF_DEPTH(4), .PL_DEPTH(4)) i_pkt_encap (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .hf_pop(hf_pop), .hf_data(hf_data), .hf_empty(hf_empty),
        .pl_pop(pl_pop), .pl_data(pl_data), .pl_empty(pl_empty)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit cons_en = 1'b0;
    bit finished = 1'b0;

    logic [127:0] exp_hf[$];
    string        tag_hf[$];
    logic [127:0] exp_pl[$];
    string        tag_pl[$];

    int          seq_m = 0;
    logic [7:0]  dest_m = '0;
    logic [31:0] tag_m = '0;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 2'd0) dest_m = d[7:0];
        if (a == 2'd1) tag_m = d;
    endtask

    task automatic send_word(input logic [31:0] d, input logic s, input logic e);
        bit done = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        while (!done) begin
            #9;
            done = in_ready;
            @(posedge clk);
            if (!done) @(negedge clk);
        end
        #1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    // builds the expected words and sends one record
    task automatic send_record(input int size, input int pkt, input string htag);
        int words = (size + 3) / 4;
        int kept  = (words > MAXB/4) ? MAXB/4 : words;
        int beats = (kept + 3) / 4;
        int len   = (size > MAXB) ? MAXB : size;
        logic [127:0] h, f, b;
        h = '0; h[127:126] = 2'b01; h[15:0] = 16'(len);
        h[23:16] = dest_m; h[95:64] = tag_m;
        exp_hf.push_back(h); tag_hf.push_back(htag);
        for (int k = 0; k < beats; k++) begin
            b = '0;
            for (int l = 0; l < 4; l++) begin
                if (k*4 + l < kept) b[l*32 +: 32] = 32'(pkt*1000 + k*4 + l + 1);
            end
            exp_pl.push_back(b);
            tag_pl.push_back((kept % 4 != 0 && k == beats-1) ? "R4" : "R3");
        end
        f = '0; f[127:126] = 2'b10; f[15:0] = 16'(seq_m); f[32] = (size > MAXB);
        exp_hf.push_back(f);
        tag_hf.push_back(size > MAXB ? "R6" : (size == 0 ? "R11" : "R5"));
        seq_m++;
        send_word(32'(size), 1'b1, words == 0);
        for (int i = 0; i < words; i++) begin
            send_word(32'(pkt*1000 + i + 1), 1'b0, i == words-1);
        end
    endtask

    // consumer with random stalls
    initial begin
        forever begin
            @(negedge clk);
            hf_pop = 1'b0; pl_pop = 1'b0;
            #2;
            if (cons_en && !hf_empty && ($urandom % 4 != 0)) begin
                if (exp_hf.size() == 0) begin
                    check("R7", hf_data, 128'hx);
                end else begin
                    check(tag_hf.pop_front(), hf_data, exp_hf.pop_front());
                end
                hf_pop = 1'b1;
            end
            if (cons_en && !pl_empty && ($urandom % 4 != 0)) begin
                if (exp_pl.size() == 0) begin
                    check("R7", pl_data, 128'hx);
                end else begin
                    check(tag_pl.pop_front(), pl_data, exp_pl.pop_front());
                end
                pl_pop = 1'b1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got hung expected completion");
            summary();
        end
    end

    task automatic wait_drain();
        int t = 0;
        while ((exp_hf.size() != 0 || exp_pl.size() != 0) && t < 5000) begin
            @(negedge clk); t++;
        end
        repeat (4) @(negedge clk);
        check("R7", 128'(exp_hf.size() + exp_pl.size()), 128'd0);
        check("R7", {126'd0, hf_empty, pl_empty}, 128'd3);
    endtask

    initial begin
        int pkt = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #5;
        // R1 reset state
        check("R1", {125'd0, in_ready, hf_empty, pl_empty}, 128'd7);

        cons_en = 1'b1;
        cfg_write(2'd0, 32'h0000_00A7);
        cfg_write(2'd1, 32'hCAFE_1234);
        // R10: unused address must leave both fields alone
        cfg_write(2'd2, 32'hFFFF_FFFF);
        cfg_write(2'd3, 32'h5555_5555);
        send_record(12, pkt, "R10"); pkt++;

        // R11 zero-length record
        send_record(0, pkt, "R11"); pkt++;

        // R8: stray words while idle
        send_word(32'hDEAD_0001, 1'b0, 1'b0);
        send_word(32'hDEAD_0002, 1'b0, 1'b1);
        send_record(8, pkt, "R8"); pkt++;

        // sweep of lengths, including above the limit (R6)
        for (int s = 0; s <= MAXB + 8; s++) begin
            if (s % 7 == 3) cfg_write(2'd0, 32'(s * 3 + 1));
            send_record(s, pkt, s > MAXB ? "R6" : "R2"); pkt++;
        end
        wait_drain();

        // R9: stop reading, fill both FIFOs
        cons_en = 1'b0;
        fork
            begin
                for (int r = 0; r < 4; r++) begin
                    send_record(MAXB, pkt + r, "R9");
                end
            end
        join_none
        repeat (200) @(negedge clk);
        #9;
        check("R9", {127'd0, in_ready}, 128'd0);
        @(negedge clk);
        cons_en = 1'b1;
        wait fork;
        pkt += 4;
        wait_drain();

        finished = 1'b1;
        summary();
    end

endmodule